// File: doc/BRIEF.md
# Wallace Multiplier with Bypassing Counters

This block multiplies two unsigned N-bit operands with a Wallace reduction tree. An AND array forms the N partial-product rows in parallel. The rows are then compressed, stage by stage, in sets of three until only two rows are left, and a carry-propagate adder sums those two rows into the 2N-bit product. The product and a count of busy counters are captured in an output register, so results appear one clock after the operands.

Every (3,2) and (2,2) counter in the tree can bypass its adder. A control bit formed from the counter's own operands decides whether the adder works. When the control bit is low, the adder inputs are gated to zero and a pass-through value is steered to the outputs. Operands with many zero bits therefore leave most adder cells idle, and the result is unchanged. The registered count of counters whose control bit is high shows how much of the tree was switching for a given operand pair.

Top module: `wallace_bypass_mul`

## Requirements
- R1: One cycle after operands `a_i` and `b_i` are presented outside reset, `prod_o` equals the exact unsigned product `a_i * b_i` in 2N bits, for every operand pair.
- R2: Partial-product row i equals `a_i` shifted left by i when bit i of `b_i` is 1, and is all zeros otherwise.
- R3: A stage holding p rows reduces floor(p/3) sets of three rows to two rows each and forwards the other p mod 3 rows unchanged, so the height goes from w to 2*floor(w/3) + (w mod 3), starting at N, until two rows remain.
- R4: A (3,2) counter with inputs a, b and ci has control cs = a OR b. When cs is 1, its sum and carry are the full-adder sum and carry of a, b and ci.
- R5: When cs is 0 in a (3,2) counter, its adder inputs are held at 0, its sum equals ci and its carry is 0.
- R6: A (2,2) counter uses its input a as control. With a = 1 it outputs the half-adder sum and carry of a and b. With a = 0 its sum equals b and its carry is 0.
- R7: `act_cnt_o` is the registered number of counters whose control bit is 1. It is 0 whenever either operand is 0, and it is lower for sparse operands (both equal to 1) than for full operands (both all ones).
- R8: While `rst` is high at a rising clock edge, both `prod_o` and `act_cnt_o` are cleared to 0 at that edge.
- R9: For every input combination, each counter's {carry, sum} equals the binary count of its input ones, in bypass mode as well as in normal mode.
- R10: A carry-propagate adder sums the two final rows, and the result is the product modulo 2^(2N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results are registered on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | N | Multiplicand, unsigned |
| b_i | input | N | Multiplier, unsigned; bit i selects partial-product row i |
| prod_o | output | 2N | Registered product |
| act_cnt_o | output | clog2(N*N+1) | Registered count of counters with their control bit high |

## Verification
The bench builds the multiplier twice, with N = 4 and with N = 5, and applies every operand pair to each. With N = 4 the tree runs the height sequence 4, 3, 2, which leaves a single forwarded row at one stage. With N = 5 the sequence is 5, 4, 3, 2, which also includes a stage that forwards two rows. Between them the two builds exercise both remainder cases of the reduction, top-column carries, and every product value. Each counter type is also swept through all of its input combinations, which checks the bypass outputs directly. Operand pairs that are zero, sparse or all ones check whether the activity count follows the operand density.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    localparam int MAX_N = 32;
    localparam int MAX_W = 2 * MAX_N;

    typedef logic [MAX_W-1:0] colmask_t;

    typedef struct packed {
        logic carry;
        logic sum;
    } cnt_res_t;

    // Height of the bit matrix after s reduction stages.
    function automatic int rows_after(int n, int s);
        int p;
        p = n;
        for (int i = 0; i < s; i++) begin
            p = 2 * (p / 3) + (p % 3);
        end
        return p;
    endfunction

    // Number of reduction stages needed to reach two rows.
    function automatic int stage_count(int n);
        int p;
        int k;
        p = n;
        k = 0;
        while (p > 2) begin
            p = 2 * (p / 3) + (p % 3);
            k++;
        end
        return k;
    endfunction

    // Columns that can hold a nonzero bit in row r after s stages.
    function automatic colmask_t row_mask(int n, int s, int r);
        logic [MAX_N-1:0][MAX_W-1:0] m;
        logic [MAX_N-1:0][MAX_W-1:0] nm;
        colmask_t t0, t1, t2;
        int p, np, g;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[i] = ((colmask_t'(1) << n) - colmask_t'(1)) << i;
        end
        p = n;
        for (int st = 0; st < s; st++) begin
            nm = '0;
            np = 0;
            g  = p / 3;
            for (int k = 0; k < g; k++) begin
                t0 = m[3*k];
                t1 = m[3*k+1];
                t2 = m[3*k+2];
                nm[np]   = t0 | t1 | t2;
                nm[np+1] = ((t0 & t1) | (t0 & t2) | (t1 & t2)) << 1;
                np = np + 2;
            end
            for (int k = 3 * g; k < p; k++) begin
                nm[np] = m[k];
                np = np + 1;
            end
            m = nm;
            p = np;
        end
        return m[r];
    endfunction

endpackage

// File: rtl/wbm_csa32.sv
module wbm_csa32
    import wbm_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     ci_i,
    output cnt_res_t res_o,
    output logic     act_o
);
    logic     cs;
    logic     ga, gb;
    cnt_res_t fa;
    cnt_res_t pass;

    assign cs = a_i | b_i;
    // operand isolation: adder sees zeros when idle
    assign ga = a_i & cs;
    assign gb = b_i & cs;

    assign fa.sum   = ga ^ gb ^ ci_i;
    assign fa.carry = (ga & gb) | (ci_i & (ga ^ gb));

    assign pass.sum   = ci_i;
    assign pass.carry = 1'b0;

    assign res_o = cs ? fa : pass;
    assign act_o = cs;
endmodule

// File: rtl/wbm_cnt22.sv
module wbm_cnt22
    import wbm_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    output cnt_res_t res_o,
    output logic     act_o
);
    logic     cs;
    logic     gb;
    cnt_res_t ha;
    cnt_res_t pass;

    assign cs = a_i;
    assign gb = b_i & cs;

    assign ha.sum   = cs ^ gb;
    assign ha.carry = cs & gb;

    assign pass.sum   = b_i;
    assign pass.carry = 1'b0;

    assign res_o = cs ? ha : pass;
    assign act_o = cs;
endmodule

// File: rtl/wbm_cpa.sv
module wbm_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o
);
    assign s_o = x_i + y_i;
endmodule

// File: rtl/wallace_bypass_mul.sv
module wallace_bypass_mul
    import wbm_pkg::*;
#(
    parameter  int N  = 8,
    localparam int W  = 2 * N,
    localparam int CW = $clog2(N * N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  a_i,
    input  logic [N-1:0]  b_i,
    output logic [W-1:0]  prod_o,
    output logic [CW-1:0] act_cnt_o
);
    localparam int S  = stage_count(N);
    localparam int RM = N;
    localparam int GM = N / 3;

    logic [W-1:0]  mat [0:S][0:RM-1];
    logic [W-1:0]  act [0:S-1][0:GM-1];
    logic [W-1:0]  sum_w;
    logic [CW-1:0] cnt_w;

    // AND array
    for (genvar r = 0; r < N; r++) begin : g_pp
        assign mat[0][r] = W'({N{b_i[r]}} & a_i) << r;
    end

    for (genvar s = 0; s < S; s++) begin : g_stg
        localparam int P  = rows_after(N, s);
        localparam int G  = P / 3;
        localparam int NP = rows_after(N, s + 1);

        for (genvar g = 0; g < GM; g++) begin : g_grp
            if (g < G) begin : g_on
                localparam colmask_t M0 = row_mask(N, s, 3 * g);
                localparam colmask_t M1 = row_mask(N, s, 3 * g + 1);
                localparam colmask_t M2 = row_mask(N, s, 3 * g + 2);
                for (genvar c = 0; c < W; c++) begin : g_col
                    localparam int V  = int'(M0[c]) + int'(M1[c]) + int'(M2[c]);
                    localparam int IX = M0[c] ? 3 * g : 3 * g + 1;
                    localparam int IY = M2[c] ? 3 * g + 2 : 3 * g + 1;
                    if (c == W - 1) begin : g_top
                        // carries out of the top column are zero since A*B < 2^W
                        assign mat[s+1][2*g][c] = mat[s][3*g][c] ^ mat[s][3*g+1][c]
                                                ^ mat[s][3*g+2][c];
                        assign act[s][g][c] = 1'b0;
                    end else if (V == 3) begin : g_fa
                        cnt_res_t res;
                        wbm_csa32 u_csa (
                            .a_i  (mat[s][3*g][c]),
                            .b_i  (mat[s][3*g+1][c]),
                            .ci_i (mat[s][3*g+2][c]),
                            .res_o(res),
                            .act_o(act[s][g][c])
                        );
                        assign mat[s+1][2*g][c]     = res.sum;
                        assign mat[s+1][2*g+1][c+1] = res.carry;
                    end else if (V == 2) begin : g_ha
                        cnt_res_t res;
                        wbm_cnt22 u_cnt (
                            .a_i  (mat[s][IX][c]),
                            .b_i  (mat[s][IY][c]),
                            .res_o(res),
                            .act_o(act[s][g][c])
                        );
                        assign mat[s+1][2*g][c]     = res.sum;
                        assign mat[s+1][2*g+1][c+1] = res.carry;
                    end else begin : g_wire
                        assign mat[s+1][2*g][c]     = mat[s][3*g][c] | mat[s][3*g+1][c]
                                                    | mat[s][3*g+2][c];
                        assign mat[s+1][2*g+1][c+1] = 1'b0;
                        assign act[s][g][c]         = 1'b0;
                    end
                    if (c == 0) begin : g_c0
                        assign mat[s+1][2*g+1][0] = 1'b0;
                    end
                end
            end else begin : g_off
                assign act[s][g] = '0;
            end
        end

        // rows outside any three-row set move down unchanged
        for (genvar k = 0; k < RM; k++) begin : g_pass
            if (k >= 2 * G && k < NP) begin : g_fwd
                assign mat[s+1][k] = mat[s][k+G];
            end else if (k >= NP) begin : g_zero
                assign mat[s+1][k] = '0;
            end
        end
    end

    always_comb begin
        cnt_w = '0;
        for (int s = 0; s < S; s++) begin
            for (int g = 0; g < GM; g++) begin
                cnt_w = cnt_w + CW'($countones(act[s][g]));
            end
        end
    end

    wbm_cpa #(.W(W)) u_cpa (
        .x_i(mat[S][0]),
        .y_i(mat[S][1]),
        .s_o(sum_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_o    <= '0;
            act_cnt_o <= '0;
        end else begin
            prod_o    <= sum_w;
            act_cnt_o <= cnt_w;
        end
    end
endmodule

// File: rtl/wbm_mul_chk.sv
module wbm_mul_chk #(
    parameter  int N  = 8,
    localparam int W  = 2 * N,
    localparam int CW = $clog2(N * N + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  a_i,
    input logic [N-1:0]  b_i,
    input logic [W-1:0]  prod_o,
    input logic [CW-1:0] act_cnt_o
);
    logic [W-1:0] a_w, b_w;
    assign a_w = W'(a_i);
    assign b_w = W'(b_i);

    // R1, R10: registered exact product
    assert_product_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (prod_o == W'($past(a_w) * $past(b_w))));

    // R7: zero operand leaves every counter bypassed
    assert_zero_idle_R7: assert property (@(posedge clk) disable iff (rst)
        ((a_i == '0) || (b_i == '0)) |=> (act_cnt_o == '0));

    // R7: activity depends only on the operands
    assert_act_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(a_i) && $stable(b_i)) |=> $stable(act_cnt_o));

    // R8: reset clears both outputs
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> ((prod_o == '0) && (act_cnt_o == '0)));
endmodule

bind wallace_bypass_mul wbm_mul_chk #(.N(N)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .a_i      (a_i),
    .b_i      (b_i),
    .prod_o   (prod_o),
    .act_cnt_o(act_cnt_o)
);

// File: tb/wallace_bypass_mul_tb.sv
`timescale 1ns/1ps
module wallace_bypass_mul_tb_top;
    import wbm_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [3:0] a4 = '0, b4 = '0;
    logic [7:0] p4;
    logic [4:0] c4;
    logic [4:0] a5 = '0, b5 = '0;
    logic [9:0] p5;
    logic [4:0] c5;

    logic     ta = 1'b0, tb = 1'b0, tc = 1'b0;
    cnt_res_t r32, r22;
    logic     k32, k22;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    wallace_bypass_mul #(.N(4)) dut_i (
        .clk(clk), .rst(rst), .a_i(a4), .b_i(b4), .prod_o(p4), .act_cnt_o(c4)
    );
    wallace_bypass_mul #(.N(5)) dut5_i (
        .clk(clk), .rst(rst), .a_i(a5), .b_i(b5), .prod_o(p5), .act_cnt_o(c5)
    );
    wbm_csa32 u_c32 (.a_i(ta), .b_i(tb), .ci_i(tc), .res_o(r32), .act_o(k32));
    wbm_cnt22 u_c22 (.a_i(ta), .b_i(tb), .res_o(r22), .act_o(k22));

    task automatic check(input string tag, input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int act_full;
        int act_sparse;
        // R8: reset state
        @(negedge clk);
        @(negedge clk);
        check("R8 p4", p4, 0);
        check("R8 c4", c4, 0);
        check("R8 p5", p5, 0);

        // R4 R5 R9: (3,2) counter over all inputs
        for (int v = 0; v < 8; v++) begin
            {ta, tb, tc} = 3'(v);
            #1;
            check("R9 csa", {r32.carry, r32.sum}, int'(ta) + int'(tb) + int'(tc));
            check("R4 cs", k32, ta | tb);
            if (!(ta | tb)) begin
                check("R5 sum", r32.sum, tc);
                check("R5 carry", r32.carry, 0);
            end
        end
        // R6 R9: (2,2) counter over all inputs
        for (int v = 0; v < 4; v++) begin
            {ta, tb} = 2'(v);
            #1;
            check("R9 ha", {r22.carry, r22.sum}, int'(ta) + int'(tb));
            if (!ta) begin
                check("R6 sum", r22.sum, tb);
                check("R6 carry", r22.carry, 0);
            end
        end

        @(negedge clk);
        rst = 1'b0;
        // R1 R2 R3 R10: exhaustive sweep, N=4
        for (int v = 0; v < 256; v++) begin
            a4 = 4'(v);
            b4 = 4'(v >> 4);
            @(negedge clk);
            check("R1 prod4", p4, int'(a4) * int'(b4));
        end
        // R1 R2 R3 R10: exhaustive sweep, N=5 (height 5,4,3,2)
        for (int v = 0; v < 1024; v++) begin
            a5 = 5'(v);
            b5 = 5'(v >> 5);
            @(negedge clk);
            check("R3 prod5", p5, int'(a5) * int'(b5));
        end

        // R7: activity against operand density
        a4 = 4'hF; b4 = 4'h0;
        @(negedge clk);
        check("R7 zero", c4, 0);
        a4 = 4'hF; b4 = 4'hF;
        @(negedge clk);
        act_full = int'(c4);
        check("R7 full>0", int'(act_full > 0), 1);
        a4 = 4'h1; b4 = 4'h1;
        @(negedge clk);
        act_sparse = int'(c4);
        check("R7 sparse<full", int'(act_sparse < act_full), 1);
        check("R1 sparse prod", p4, 1);

        // R8: reset with live operands
        a4 = 4'hD; b4 = 4'hB;
        rst = 1'b1;
        @(negedge clk);
        check("R8 p4 rerst", p4, 0);
        check("R8 c4 rerst", c4, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 after", p4, 13 * 11);

        summary();
    end
endmodule